// File: doc/BRIEF.md
# Branch Opcode Classifier

This block sorts one control-flow transfer into a branch class mask. For each transfer it receives the leading opcode byte and the escape-page second byte of the instruction at the source address, already aligned. It also receives the ModRM byte, a flag that says the relative displacement of a near call is zero, and a flag that says the opcode bytes were actually fetched. The remaining inputs are an abort flag, two flags that mark a zero source or target address, and the privilege level (kernel or user) of source and target. The result is one class bit plus one privilege bit, and it follows the classification used to filter recorded branch stacks.

Software-visible filtering logic uses the mask by testing it against a requested class set. Any transfer from user level into kernel level is reclassified as a hardware interrupt or fault unless the instruction was a system call or a software interrupt. A near relative call with a zero displacement gets its own class, separate from ordinary calls. The decode itself is combinational. The result is captured in an output register on every valid input and held otherwise.

Top module: `branch_class_unit`

## Requirements
- R1: After reset, out_valid is 0 and class_mask is all zero.
- R2: Class bit positions are: user 0, kernel 1, call 2, return 3, syscall 4, sysret 5, software interrupt 6, iret 7, conditional 8, jump 9, irq 10, indirect call 11, abort 12, in-tx 13, no-tx 14, zero call 15, call-stack 16, indirect jump 17. Bits 13, 14 and 16 are never produced by this block.
- R3: With first byte 0x0F, a second byte of 0x05 or 0x34 gives syscall, 0x07 or 0x35 gives sysret, and 0x80 to 0x8F gives conditional. Any other second byte gives no class.
- R4: First bytes 0x70 to 0x7F and 0xE0 to 0xE3 give conditional. 0xC2, 0xC3, 0xCA and 0xCB give return. 0xCF gives iret. 0xCC to 0xCE give software interrupt. 0xE9 to 0xEB give jump. 0x9A gives call. Any first byte not listed in R4, R3, R5 or R6 gives no class.
- R5: First byte 0xE8 gives zero call when imm_is_zero is 1, and call otherwise.
- R6: First byte 0xFF gives indirect call when ModRM bits [5:3] are 2 or 3, and indirect jump when they are 4 or 5. Any other value gives no class.
- R7: When src_addr_zero or dst_addr_zero is 1, the mask is all zero. This takes priority over every other input.
- R8: When abort_flag is 1 and neither address is zero, the mask is the abort bit plus the target privilege bit.
- R9: When opc_fetched is 0 and there is no zero address and no abort, the mask is the abort bit alone, with no privilege bit.
- R10: A decoded transfer from user source to kernel target becomes irq when its class is not syscall or software interrupt. This includes a transfer with no decoded class.
- R11: Every nonzero decoded class carries exactly one privilege bit: kernel (bit 1) when dst_is_kernel is 1, user (bit 0) otherwise. No class still gives an all-zero mask.
- R12: class_mask and out_valid update one clock after a valid input. out_valid equals in_valid of the previous cycle, and class_mask holds its value while in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| opc_first | input | 8 | Leading opcode byte |
| opc_second | input | 8 | Byte following a 0x0F escape |
| modrm | input | 8 | ModRM byte |
| imm_is_zero | input | 1 | Near relative call displacement is zero |
| opc_fetched | input | 1 | Opcode bytes were obtained |
| abort_flag | input | 1 | Transfer was a transaction abort |
| src_addr_zero | input | 1 | Source address is zero |
| dst_addr_zero | input | 1 | Target address is zero |
| src_is_kernel | input | 1 | Source is at kernel level |
| dst_is_kernel | input | 1 | Target is at kernel level |
| out_valid | output | 1 | class_mask updated from a valid input |
| class_mask | output | 18 | Class bit plus privilege bit |

## Verification
A wrong decode entry or a wrong priority among the zero-address, abort and missing-opcode overrides shows up on class_mask one clock after the offending input. It appears as a wrong class bit, a missing or extra privilege bit, or a nonzero mask where zero is due. A broken irq promotion shows only on user-to-kernel inputs, so the stimulus forces that pairing often. A bad output register shows either as a valid flag that is off by a cycle or as a mask that changes while no input is valid.

// File: rtl/branch_class_pkg.sv
package branch_class_pkg;
  localparam int BYTE_W = 8;
  localparam int CLS_W  = 18;

  localparam int P_USER     = 0;
  localparam int P_KERNEL   = 1;
  localparam int P_CALL     = 2;
  localparam int P_RET      = 3;
  localparam int P_SYSCALL  = 4;
  localparam int P_SYSRET   = 5;
  localparam int P_SWINT    = 6;
  localparam int P_IRET     = 7;
  localparam int P_COND     = 8;
  localparam int P_JUMP     = 9;
  localparam int P_IRQ      = 10;
  localparam int P_INDCALL  = 11;
  localparam int P_ABORT    = 12;
  localparam int P_INTX     = 13;
  localparam int P_NOTX     = 14;
  localparam int P_ZEROCALL = 15;
  localparam int P_CSTACK   = 16;
  localparam int P_INDJMP   = 17;

  typedef logic [CLS_W-1:0] cls_t;

  function automatic cls_t cls_bit(input int pos);
    return cls_t'(1) << pos;
  endfunction

  function automatic cls_t priv_of(input logic kernel);
    return kernel ? cls_bit(P_KERNEL) : cls_bit(P_USER);
  endfunction
endpackage

// File: rtl/branch_opcode_decode.sv
module branch_opcode_decode
  import branch_class_pkg::*;
(
  input  logic [BYTE_W-1:0] opc_first,
  input  logic [BYTE_W-1:0] opc_second,
  input  logic [BYTE_W-1:0] modrm,
  input  logic              imm_is_zero,
  output cls_t              base_cls
);
  function automatic cls_t dec_escape(input logic [BYTE_W-1:0] b);
    cls_t r;
    r = '0;
    if (b == 8'h05 || b == 8'h34)      r = cls_bit(P_SYSCALL);
    else if (b == 8'h07 || b == 8'h35) r = cls_bit(P_SYSRET);
    else if (b[7:4] == 4'h8)           r = cls_bit(P_COND);
    return r;
  endfunction

  function automatic cls_t dec_group(input logic [2:0] ext);
    cls_t r;
    case (ext)
      3'd2, 3'd3: r = cls_bit(P_INDCALL);
      3'd4, 3'd5: r = cls_bit(P_INDJMP);
      default:    r = '0;
    endcase
    return r;
  endfunction

  function automatic cls_t dec_primary(input logic [BYTE_W-1:0] b0,
                                       input logic [BYTE_W-1:0] b1,
                                       input logic [BYTE_W-1:0] mr,
                                       input logic              iz);
    cls_t r;
    r = '0;
    case (b0)
      8'h0F:                      r = dec_escape(b1);
      8'hC2, 8'hC3, 8'hCA, 8'hCB: r = cls_bit(P_RET);
      8'hCF:                      r = cls_bit(P_IRET);
      8'hCC, 8'hCD, 8'hCE:        r = cls_bit(P_SWINT);
      8'hE8:                      r = iz ? cls_bit(P_ZEROCALL) : cls_bit(P_CALL);
      8'h9A:                      r = cls_bit(P_CALL);
      8'hE0, 8'hE1, 8'hE2, 8'hE3: r = cls_bit(P_COND);
      8'hE9, 8'hEA, 8'hEB:        r = cls_bit(P_JUMP);
      8'hFF:                      r = dec_group(mr[5:3]);
      default:                    r = (b0[7:4] == 4'h7) ? cls_bit(P_COND) : '0;
    endcase
    return r;
  endfunction

  assign base_cls = dec_primary(opc_first, opc_second, modrm, imm_is_zero);
endmodule

// File: rtl/branch_priv_adjust.sv
module branch_priv_adjust
  import branch_class_pkg::*;
(
  input  cls_t base_cls,
  input  logic opc_fetched,
  input  logic abort_flag,
  input  logic src_addr_zero,
  input  logic dst_addr_zero,
  input  logic src_is_kernel,
  input  logic dst_is_kernel,
  output cls_t final_cls,
  output logic ring_cross,
  output logic irq_promote,
  output logic addr_void
);
  cls_t promoted;

  assign addr_void   = src_addr_zero | dst_addr_zero;
  assign ring_cross  = ~src_is_kernel & dst_is_kernel;
  assign irq_promote = ring_cross & ~base_cls[P_SYSCALL] & ~base_cls[P_SWINT];
  assign promoted    = irq_promote ? cls_bit(P_IRQ) : base_cls;

  always_comb begin
    if (addr_void)         final_cls = '0;
    else if (abort_flag)   final_cls = cls_bit(P_ABORT) | priv_of(dst_is_kernel);
    else if (!opc_fetched) final_cls = cls_bit(P_ABORT);
    else if (promoted == '0) final_cls = '0;
    else                   final_cls = promoted | priv_of(dst_is_kernel);
  end
endmodule

// File: rtl/branch_class_unit.sv
module branch_class_unit
  import branch_class_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] opc_first,
  input  logic [BYTE_W-1:0] opc_second,
  input  logic [BYTE_W-1:0] modrm,
  input  logic              imm_is_zero,
  input  logic              opc_fetched,
  input  logic              abort_flag,
  input  logic              src_addr_zero,
  input  logic              dst_addr_zero,
  input  logic              src_is_kernel,
  input  logic              dst_is_kernel,
  output logic              out_valid,
  output logic [CLS_W-1:0]  class_mask
);
  cls_t base_cls;
  cls_t final_cls;
  logic ring_cross;
  logic irq_promote;
  logic addr_void;

  branch_opcode_decode u_dec (
    .opc_first  (opc_first),
    .opc_second (opc_second),
    .modrm      (modrm),
    .imm_is_zero(imm_is_zero),
    .base_cls   (base_cls)
  );

  branch_priv_adjust u_adj (
    .base_cls     (base_cls),
    .opc_fetched  (opc_fetched),
    .abort_flag   (abort_flag),
    .src_addr_zero(src_addr_zero),
    .dst_addr_zero(dst_addr_zero),
    .src_is_kernel(src_is_kernel),
    .dst_is_kernel(dst_is_kernel),
    .final_cls    (final_cls),
    .ring_cross   (ring_cross),
    .irq_promote  (irq_promote),
    .addr_void    (addr_void)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      class_mask <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) class_mask <= final_cls;
    end
  end

  // R12 valid flag follows input by one cycle
  assert_valid_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(class_mask));
  // R7 zero address clears the mask
  assert_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_void) |=> class_mask == '0);
  // R8 abort carries the target privilege
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr_void && abort_flag) |=>
      class_mask == (cls_bit(P_ABORT) | priv_of($past(dst_is_kernel))));
  // R10 user-to-kernel promotion to irq
  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr_void && !abort_flag && opc_fetched && irq_promote) |=>
      class_mask == (cls_bit(P_IRQ) | cls_bit(P_KERNEL)));
  // R11 at most one class bit, one privilege bit when classed
  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(class_mask[CLS_W-1:2]));
  assert_priv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && class_mask[CLS_W-1:2] != '0 && class_mask != cls_bit(P_ABORT))
      |-> $countones(class_mask[1:0]) == 1);
  // R2 unused class bits stay clear
  assert_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!class_mask[P_INTX] && !class_mask[P_NOTX] && !class_mask[P_CSTACK]));
endmodule

// File: tb/branch_class_unit_bench.sv
`timescale 1ns/100ps
module branch_class_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] opc_first = 8'h00, opc_second = 8'h00, modrm = 8'h00;
  logic       imm_is_zero = 1'b0, opc_fetched = 1'b1, abort_flag = 1'b0;
  logic       src_addr_zero = 1'b0, dst_addr_zero = 1'b0;
  logic       src_is_kernel = 1'b0, dst_is_kernel = 1'b0;
  logic       out_valid;
  logic [17:0] class_mask;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  branch_class_unit u_branch_class_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opc_first(opc_first), .opc_second(opc_second), .modrm(modrm),
    .imm_is_zero(imm_is_zero), .opc_fetched(opc_fetched), .abort_flag(abort_flag),
    .src_addr_zero(src_addr_zero), .dst_addr_zero(dst_addr_zero),
    .src_is_kernel(src_is_kernel), .dst_is_kernel(dst_is_kernel),
    .out_valid(out_valid), .class_mask(class_mask)
  );

  // class index per R2; -1 means no class
  function automatic int base_index(logic [7:0] b0, logic [7:0] b1, logic [7:0] m, logic iz);
    int idx;
    idx = -1;
    if (b0 == 8'h0F) begin
      if (b1 inside {8'h05, 8'h34}) idx = 4;
      if (b1 inside {8'h07, 8'h35}) idx = 5;
      if (b1 >= 8'h80 && b1 <= 8'h8F) idx = 8;
    end
    if ((b0 >= 8'h70 && b0 <= 8'h7F) || (b0 >= 8'hE0 && b0 <= 8'hE3)) idx = 8;
    if (b0 inside {8'hC2, 8'hC3, 8'hCA, 8'hCB}) idx = 3;
    if (b0 == 8'hCF) idx = 7;
    if (b0 >= 8'hCC && b0 <= 8'hCE) idx = 6;
    if (b0 >= 8'hE9 && b0 <= 8'hEB) idx = 9;
    if (b0 == 8'h9A) idx = 2;
    if (b0 == 8'hE8) idx = iz ? 15 : 2;
    if (b0 == 8'hFF) begin
      if (m[5:3] == 3'd2 || m[5:3] == 3'd3) idx = 11;
      if (m[5:3] == 3'd4 || m[5:3] == 3'd5) idx = 17;
    end
    return idx;
  endfunction

  function automatic logic [17:0] expect_mask(logic [7:0] b0, logic [7:0] b1, logic [7:0] m,
      logic iz, logic fetched, logic ab, logic sz, logic dz, logic sk, logic dk);
    int idx;
    logic [17:0] pv;
    pv = dk ? 18'h2 : 18'h1;
    if (sz || dz) return 18'h0;
    if (ab) return 18'h1000 | pv;
    if (!fetched) return 18'h1000;
    idx = base_index(b0, b1, m, iz);
    if (!sk && dk && idx != 4 && idx != 6) idx = 10;
    if (idx < 0) return 18'h0;
    return (18'h1 << idx) | pv;
  endfunction

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result appears at next negedge after one posedge
  task automatic apply(string req, logic [7:0] b0, logic [7:0] b1, logic [7:0] m, logic iz,
      logic f, logic ab, logic sz, logic dz, logic sk, logic dk);
    logic [17:0] e;
    e = expect_mask(b0, b1, m, iz, f, ab, sz, dz, sk, dk);
    opc_first = b0; opc_second = b1; modrm = m; imm_is_zero = iz; opc_fetched = f;
    abort_flag = ab; src_addr_zero = sz; dst_addr_zero = dz;
    src_is_kernel = sk; dst_is_kernel = dk; in_valid = 1'b1;
    @(negedge clk);
    check(req, class_mask, e);
    check({req, "_valid"}, {17'b0, out_valid}, 18'h1);
  endtask

  initial begin
    logic [17:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1", class_mask, 18'h0);
    check("R1_valid", {17'b0, out_valid}, 18'h0);
    rst_n = 1'b1;

    // R3 escape page
    apply("R3", 8'h0F, 8'h05, 0, 0, 1, 0, 0, 0, 0, 0);
    check("R3", class_mask, 18'h10 | 18'h1);
    apply("R3", 8'h0F, 8'h35, 0, 0, 1, 0, 0, 0, 1, 1);
    check("R3", class_mask, 18'h20 | 18'h2);
    apply("R3", 8'h0F, 8'h8F, 0, 0, 1, 0, 0, 0, 0, 0);
    apply("R3", 8'h0F, 8'h90, 0, 0, 1, 0, 0, 0, 0, 0);
    check("R3", class_mask, 18'h0);
    // R4 single-byte
    apply("R4", 8'h70, 0, 0, 0, 1, 0, 0, 0, 1, 1);
    apply("R4", 8'hE3, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    apply("R4", 8'hCB, 0, 0, 0, 1, 0, 0, 0, 1, 1);
    check("R4", class_mask, 18'h8 | 18'h2);
    apply("R4", 8'hCF, 0, 0, 0, 1, 0, 0, 0, 1, 0);
    apply("R4", 8'hEB, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    apply("R4", 8'h9A, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    apply("R4", 8'h90, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check("R4", class_mask, 18'h0);
    // R5 near relative call
    apply("R5", 8'hE8, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    check("R5", class_mask, 18'h8000 | 18'h1);
    apply("R5", 8'hE8, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check("R5", class_mask, 18'h4 | 18'h1);
    // R6 group opcode
    apply("R6", 8'hFF, 0, 8'h10, 0, 1, 0, 0, 0, 1, 1);
    check("R6", class_mask, 18'h800 | 18'h2);
    apply("R6", 8'hFF, 0, 8'h28, 0, 1, 0, 0, 0, 0, 0);
    check("R6", class_mask, 18'h20000 | 18'h1);
    apply("R6", 8'hFF, 0, 8'h30, 0, 1, 0, 0, 0, 0, 0);
    check("R6", class_mask, 18'h0);
    // R7 zero address beats abort
    apply("R7", 8'hC3, 0, 0, 0, 1, 1, 1, 0, 0, 1);
    check("R7", class_mask, 18'h0);
    apply("R7", 8'hC3, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R8 abort
    apply("R8", 8'h90, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    check("R8", class_mask, 18'h1000 | 18'h2);
    // R9 missing opcode
    apply("R9", 8'hC3, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R9", class_mask, 18'h1000);
    // R10 promotion
    apply("R10", 8'hEB, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    check("R10", class_mask, 18'h400 | 18'h2);
    apply("R10", 8'h90, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    check("R10", class_mask, 18'h400 | 18'h2);
    apply("R10", 8'hCD, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    check("R10", class_mask, 18'h40 | 18'h2);
    apply("R10", 8'h0F, 8'h34, 0, 0, 1, 0, 0, 0, 0, 1);
    check("R10", class_mask, 18'h10 | 18'h2);
    // R11 privilege from target
    apply("R11", 8'h75, 0, 0, 0, 1, 0, 0, 0, 1, 0);
    check("R11", class_mask, 18'h100 | 18'h1);

    // R12 hold while idle
    held = class_mask;
    in_valid = 1'b0; opc_first = 8'hC3; dst_is_kernel = 1'b1;
    @(negedge clk);
    check("R12", class_mask, held);
    check("R12_valid", {17'b0, out_valid}, 18'h0);
    @(negedge clk);
    check("R12", class_mask, held);

    // random mix, including R2 bit layout via reference model
    for (int i = 0; i < 600; i++) begin
      logic [7:0] b0;
      int pick;
      pick = $urandom_range(0, 11);
      case (pick)
        0: b0 = 8'h0F;
        1: b0 = 8'hE8;
        2: b0 = 8'hFF;
        3: b0 = 8'h70 + 8'($urandom_range(0, 15));
        4: b0 = 8'hC0 + 8'($urandom_range(0, 15));
        5: b0 = 8'hE0 + 8'($urandom_range(0, 11));
        6: b0 = 8'h9A;
        default: b0 = 8'($urandom);
      endcase
      apply("R2", b0,
            ($urandom_range(0, 1) != 0) ? (8'h80 | 8'($urandom_range(0, 15))) : 8'($urandom),
            8'($urandom), 1'($urandom), ($urandom_range(0, 9) != 0),
            ($urandom_range(0, 9) == 0), ($urandom_range(0, 14) == 0),
            ($urandom_range(0, 14) == 0), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        held = class_mask;
        in_valid = 1'b0;
        opc_first = 8'($urandom);
        @(negedge clk);
        check("R12", class_mask, held);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule